// File: doc/BRIEF.md
# Frame Interrupt Controller

This block raises a processor interrupt when chosen moments of a display frame occur. The display timing generator supplies four phase level signals: back porch, vertical sync, active region and front porch. Two independent selectors each choose one of these phases. The second selector can also choose no event at all. Each selector has its own pending bit. That bit latches on the first clock of the selected phase and holds until software clears it.

Software reaches the block through a small register bus with two addresses: a control word and a pending word. The interrupt line is driven only while both the global enable and the frame enable are set and at least one pending bit is held. Pending bits are cleared by writing one to them. Turning an enable off masks the line but keeps the pending state, so no event is lost while masked.

Top module: `frame_irq_ctrl`

## Requirements
- R1: After reset the control word reads 0, the pending word reads 0 and `irq_o` is low.
- R2: The control word at address 0 is laid out as follows. Bit 0 is the global enable, bit 1 is the frame enable, bits [3:2] are selector A and bits [6:4] are selector B. Bits above bit 6 ignore writes and read 0.
- R3: The bits of `phase_i` are 0 back porch, 1 vertical sync, 2 active start and 3 front porch. Selector codes 0 to 3 pick the `phase_i` bit of the same number. Pending bit 0 (selector A) or bit 1 (selector B) sets at the clock edge where the selected phase input is high and was low at the previous edge.
- R4: A selected phase held high sets its pending bit only on its first clock. If the bit is cleared while the phase stays high, it stays clear.
- R5: Selector B codes 4 to 7 mean no event, and pending bit 1 then never sets.
- R6: The pending word at address 1 shows the bits in [1:0]. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and bits above bit 1 read 0.
- R7: If an event for a pending bit arrives on the same edge as a write that clears that bit, the bit is set after the edge.
- R8: `irq_o` is high exactly when global enable, frame enable and at least one pending bit are all set. It is combinational from the registers.
- R9: Clearing either enable drops `irq_o` without changing the pending bits. Setting both enables again while a bit is still pending raises `irq_o` again.
- R10: Phase edges on inputs that no selector chooses are ignored. Writes to the pending address leave the control word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_i | input | 4 | Frame phase levels from the timing generator |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register address: 0 control, 1 pending |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a phase rising edge that meets a write-one-to-clear on the same clock. It only happens when software clears the bit at the exact moment a new frame event arrives. The bench drives the clear write and the rising phase level on the same falling edge, so both land on one rising edge. It runs this once with the bit already pending and once with it clear. A second hard case is a phase held high across a clear, which shows that only the first clock of a phase counts. The bench raises the phase, clears the pending bit while the phase is still high, and holds the phase for several more cycles.

// File: rtl/frame_irq_pkg.sv
package frame_irq_pkg;
  localparam int NUM_PHASES = 4;
  localparam int NUM_SRC    = 2;
  localparam int SELA_W     = 2;
  localparam int SELB_W     = 3;

  typedef struct packed {
    logic [SELB_W-1:0] sel_b;
    logic [SELA_W-1:0] sel_a;
    logic              frame_en;
    logic              glob_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/frame_phase_edge.sv
module frame_phase_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] level_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/frame_evt_sel.sv
module frame_evt_sel #(
  parameter int N     = 4,
  parameter int SEL_W = 2
) (
  input  logic [N-1:0]     rise_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             evt_o
);
  always_comb begin
    evt_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel_i == SEL_W'(i)) evt_o = rise_i[i];
    end
  end
endmodule

// File: rtl/frame_pend_bank.sv
module frame_pend_bank #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  for (genvar k = 0; k < NSRC; k++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_o[k] <= 1'b0;
      else if (evt_i[k]) pend_o[k] <= 1'b1;
      else if (clr_i[k]) pend_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/frame_irq_regs.sv
module frame_irq_regs
  import frame_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [NUM_SRC-1:0] pend_i,
  output ctrl_t              ctrl_o,
  output logic [NUM_SRC-1:0] clr_o,
  output logic [DATA_W-1:0]  rdata_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ctrl_o <= '0;
    else if (bus_wr && !bus_addr) ctrl_o <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  assign clr_o = (bus_wr && bus_addr) ? bus_wdata[NUM_SRC-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (bus_addr) rdata_o[NUM_SRC-1:0] = pend_i;
    else          rdata_o[CTRL_W-1:0]  = ctrl_o;
  end
endmodule

// File: rtl/frame_irq_ctrl.sv
module frame_irq_ctrl
  import frame_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PHASES-1:0] phase_i,
  input  logic                  bus_wr,
  input  logic                  bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  irq_o
);
  logic [NUM_PHASES-1:0] rise;
  logic [NUM_SRC-1:0]    evt;
  logic [NUM_SRC-1:0]    clr_mask;
  logic [NUM_SRC-1:0]    pend_q;
  ctrl_t                 ctrl_q;

  frame_phase_edge #(.N(NUM_PHASES)) u_edge (
    .clk(clk), .rst_n(rst_n), .level_i(phase_i), .rise_o(rise)
  );

  frame_evt_sel #(.N(NUM_PHASES), .SEL_W(SELA_W)) u_sel_a (
    .rise_i(rise), .sel_i(ctrl_q.sel_a), .evt_o(evt[0])
  );

  frame_evt_sel #(.N(NUM_PHASES), .SEL_W(SELB_W)) u_sel_b (
    .rise_i(rise), .sel_i(ctrl_q.sel_b), .evt_o(evt[1])
  );

  frame_pend_bank #(.NSRC(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_i(clr_mask), .pend_o(pend_q)
  );

  frame_irq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pend_i(pend_q), .ctrl_o(ctrl_q),
    .clr_o(clr_mask), .rdata_o(bus_rdata)
  );

  assign irq_o = ctrl_q.glob_en & ctrl_q.frame_en & (|pend_q);
endmodule

// File: rtl/frame_irq_chk.sv
module frame_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] ctrl,
  input logic [1:0] pend,
  input logic [1:0] evt,
  input logic [1:0] clr,
  input logic       irq
);
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl[0] && ctrl[1]) |-> !irq); // R9
  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && ctrl[1] && (|pend)) |-> irq); // R8
  AST_EVT_SETS_A: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |=> pend[0]); // R7
  AST_EVT_SETS_B: assert property (@(posedge clk) disable iff (!rst_n)
    evt[1] |=> pend[1]); // R3
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] && !clr[0]) |=> pend[0]); // R6
  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[0] && !evt[0]) |=> !pend[0]); // R6
  AST_NONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[6] && !pend[1]) |=> !pend[1]); // R5
endmodule

bind frame_irq_ctrl frame_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .pend(pend_q),
  .evt(evt), .clr(clr_mask), .irq(irq_o)
);

// File: tb/frame_irq_ctrl_test.sv
module frame_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  phase_i = '0;
  logic        bus_wr = 1'b0;
  logic        bus_addr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  frame_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .phase_i(phase_i), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  // Vector fields: control[13:7], phase pulse[6:3], expected pending[2:1], expected irq[0]
  localparam logic [13:0] VEC [0:7] = '{
    {7'h47, 4'b0010, 2'b01, 1'b1},
    {7'h47, 4'b1101, 2'b00, 1'b0},
    {7'h23, 4'b0101, 2'b11, 1'b1},
    {7'h3E, 4'b1000, 2'b11, 1'b0},
    {7'h09, 4'b0100, 2'b01, 1'b0},
    {7'h1B, 4'b0010, 2'b10, 1'b1},
    {7'h73, 4'b1111, 2'b01, 1'b1},
    {7'h73, 4'b0000, 2'b00, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(logic [3:0] p);
    @(negedge clk);
    phase_i = p;
    @(negedge clk);
    phase_i = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(1'b0, r); check("R1 ctrl", r, 32'h0);
    rd(1'b1, r); check("R1 pend", r, 32'h0);
    check("R1 irq", {31'h0, irq_o}, 32'h0);

    // R3 R5 R8 R10 table walk
    for (int i = 0; i < 8; i++) begin
      wr(1'b1, 32'h3);
      wr(1'b0, {25'h0, VEC[i][13:7]});
      pulse(VEC[i][6:3]);
      rd(1'b1, r); check("R3 R5 R10 vector pend", r, {30'h0, VEC[i][2:1]});
      check("R8 vector irq", {31'h0, irq_o}, {31'h0, VEC[i][0]});
    end

    // R2 layout and unused bits
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, r); check("R2 ctrl readback", r, 32'h7F);

    // R10 pending write leaves ctrl
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b0, r); check("R10 ctrl after pend write", r, 32'h7F);

    // R6 write zero keeps, write one clears, upper bits zero
    wr(1'b0, 32'h23);
    pulse(4'b0101);
    wr(1'b1, 32'hFFFF_FFFC);
    rd(1'b1, r); check("R6 write zero keeps", r, 32'h3);
    wr(1'b1, 32'h1);
    rd(1'b1, r); check("R6 clear bit0 only", r, 32'h2);

    // R9 mask keeps pending, re-enable raises irq
    wr(1'b0, 32'h21);
    check("R9 masked irq", {31'h0, irq_o}, 32'h0);
    rd(1'b1, r); check("R9 pend kept", r, 32'h2);
    wr(1'b0, 32'h23);
    check("R9 re-enable irq", {31'h0, irq_o}, 32'h1);

    // R4 held phase counts once
    wr(1'b0, 32'h47);
    wr(1'b1, 32'h3);
    @(negedge clk); phase_i = 4'b0010;
    @(negedge clk);
    rd(1'b1, r); check("R4 first clock sets", r, 32'h1);
    bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 32'h1;
    @(negedge clk); bus_wr = 1'b0;
    repeat (4) @(negedge clk);
    rd(1'b1, r); check("R4 held level no reset", r, 32'h0);
    phase_i = '0;
    @(negedge clk);

    // R7 event and clear on same edge, bit already set
    pulse(4'b0010);
    rd(1'b1, r); check("R7 precondition", r, 32'h1);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 32'h1; phase_i = 4'b0010;
    @(negedge clk);
    bus_wr = 1'b0; phase_i = '0;
    rd(1'b1, r); check("R7 set wins over clear", r, 32'h1);
    // R7 bit clear before collision
    wr(1'b1, 32'h1);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 32'h1; phase_i = 4'b0010;
    @(negedge clk);
    bus_wr = 1'b0; phase_i = '0;
    rd(1'b1, r); check("R7 set from clear", r, 32'h1);
    check("R8 irq after collision", {31'h0, irq_o}, 32'h1);

    finish_run();
  end
endmodule